// File: doc/BRIEF.md
# Cascadable Reload Down-Counter Timers

Three 8-bit down counters, each preset from its own reload register, advance on a tick taken from a shared free-running clock divider. A counter that reaches zero and receives another count tick wraps back to its reload value. On that wrap it emits a one-cycle underflow pulse and sets a sticky interrupt flag. Counter 0 may instead count synchronised edges of an external event pin. Counters 0 and 1 may be chained so that counter 1 advances once per underflow of counter 0, which forms a 16-bit timer. A selected counter's underflows toggle a timer output pin. The underflow pulses of counter 2 drive a shift-clock tick for a neighbouring serial port.

Software reaches the block through a small nibble-wide register port. It writes control, mode and reload nibbles and reads back configuration, flags and count values. Reading the low nibble of counter 0 captures counters 1 and 0 together into a 16-bit shadow. The three higher nibbles of the 16-bit value are then returned from that shadow, so a value read nibble by nibble stays coherent while the counters keep moving.

Top module: `cascade_timer`

## Requirements
- R1: After reset every count, reload, control, mode, output-select and flag register reads 0, and `tmr_out`, `irq_flag` and `ser_shift_tick` are 0.
- R2: Each counter's tick source is chosen by bits 3:2 of its control register (addresses 0, 1 and 2 for counters 0, 1 and 2). The code 0 selects clock/256, 1 selects clock/32, 2 selects clock/4 and 3 selects every clock. All divided ticks come from one free-running 8-bit divider that starts at 0 after reset.
- R3: Bit 0 of a control register is the run request. It is copied to the counter's run state only on that counter's tick. A start therefore needs one tick before the first decrement, and a stop lets exactly one more decrement happen.
- R4: While a counter runs, each tick decrements it. A tick at count 0 instead reloads it and causes an underflow: a one-cycle pulse plus setting of its flag.
- R5: Writing 1 to bit 1 of a control register loads that counter from its reload register at the same clock edge, with priority over counting. Bit 1 always reads 0.
- R6: A stopped counter keeps its count, and a later run resumes from the kept value.
- R7: With mode bit 0 (address 3) set, counter 1 ticks on counter 0's underflow and counts regardless of its own run request and tick selection.
- R8: With mode bit 1 set, counter 0 ticks on edges of `event_in` after a two-stage synchroniser, and its tick selection is ignored. Mode bit 2 picks the edge: 0 falling, 1 rising.
- R9: The flags read at address 5, bits 2:0, one bit per counter. Writing 1 to a bit clears it, and an underflow in the same cycle keeps it set.
- R10: With mode bit 3 set, `tmr_out` toggles on each underflow of the counter named at address 4, bits 1:0. The value 3 names no counter. With mode bit 3 clear, `tmr_out` is 0.
- R11: `ser_shift_tick` pulses in exactly the cycles in which counter 2 underflows.
- R12: Reload nibbles sit at addresses 6 to 11, low nibble first, for counters 0, 1 and 2 in turn. Address 12 reads counter 0's low nibble live and captures {counter 1, counter 0} into a shadow. Addresses 13, 14 and 15 read shadow bits 7:4, 11:8 and 15:12. Addresses 16 and 17 read counter 2's low and high nibbles live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; the shadow capture happens on it |
| bus_wdata | input | 4 | Write data nibble |
| bus_rdata | output | 4 | Read data nibble for `bus_addr` |
| event_in | input | 1 | Asynchronous external event input for counter 0 |
| irq_flag | output | 3 | Sticky underflow flags, bit n for counter n |
| tmr_out | output | 1 | Toggling timer output |
| ser_shift_tick | output | 1 | Counter 2 underflow pulse for a serial shifter |

## Verification
The assertions take for granted that `bus_addr`, `bus_wr`, `bus_rd` and `bus_wdata` are steady across each rising edge. They also assume at most one access per cycle, and that a load strobe may land on a count tick, in which case the load wins. The stimulus changes every input only at the falling edge and issues one register access per cycle. It holds each `event_in` level for several clocks, so every level passes through the synchroniser and yields exactly one edge.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int CNT_W  = 8;
    localparam int NCH    = 3;
    localparam int DIV_W  = 8;
    localparam int NSEL   = 4;
    localparam int ADDR_W = 5;
    localparam int NIB_W  = 4;

    // register addresses
    localparam int A_CTL0  = 0;
    localparam int A_MODE  = 3;
    localparam int A_OSEL  = 4;
    localparam int A_FLAG  = 5;
    localparam int A_RLD0L = 6;
    localparam int A_C0L   = 12;
    localparam int A_C0H   = 13;
    localparam int A_C1L   = 14;
    localparam int A_C1H   = 15;
    localparam int A_C2L   = 16;
    localparam int A_C2H   = 17;

    typedef logic [1:0] psel_t;

    typedef struct packed {
        psel_t sel;
        logic  run_req;
    } chctl_t;

    typedef struct packed {
        logic oen;
        logic evpol;
        logic evmode;
        logic chain;
    } mode_t;

    // number of low divider bits that must all be 1 for a selection code
    function automatic int tap_bits(input int code);
        case (code)
            0:       return 8;
            1:       return 5;
            2:       return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/ctmr_divider.sv
module ctmr_divider
    import ctmr_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [NSEL-1:0] tick_o
);

    logic [W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    for (genvar s = 0; s < NSEL; s++) begin : g_tap
        localparam int TB = tap_bits(s);
        if (TB == 0) begin : g_every
            assign tick_o[s] = 1'b1;
        end else begin : g_and
            assign tick_o[s] = &div_q[TB-1:0];
        end
    end

    // R2
    div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[0] |=> (div_q == '0));

endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
    import ctmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_req_i,
    input  logic         force_run_i,
    input  logic         load_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         run;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   eff_run;

    assign eff_run = st_q.run | force_run_i;
    assign uf_o    = tick_i & eff_run & (st_q.cnt == '0) & ~load_i;
    assign cnt_o   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.run = run_req_i;
        if (load_i) begin
            st_d.cnt = reload_i;
        end else if (tick_i && eff_run) begin
            if (st_q.cnt == '0) st_d.cnt = reload_i;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> (st_q.cnt == $past(reload_i)));

    // R5
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(reload_i)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick_i && eff_run) && !load_i) |=> $stable(st_q.cnt));

    // R3
    run_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.run));

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import ctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [NIB_W-1:0]  bus_wdata,
    output logic [NIB_W-1:0]  bus_rdata,
    input  logic              event_in,
    output logic [NCH-1:0]    irq_flag,
    output logic              tmr_out,
    output logic              ser_shift_tick
);

    typedef struct packed {
        chctl_t [NCH-1:0]            ctl;
        mode_t                       mode;
        logic [1:0]                  osel;
        logic [NCH-1:0][CNT_W-1:0]   rld;
        logic [NCH-1:0]              flags;
        logic                        tout;
        logic [2*CNT_W-1:0]          shadow;
        logic [2:0]                  ev;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NSEL-1:0]  ptick;
    logic             tick0, tick1, tick2;
    logic             uf0, uf1, uf2;
    logic             load0, load1, load2;
    logic [CNT_W-1:0] cnt0, cnt1, cnt2;
    logic [NCH-1:0]   uf_vec;
    logic             ev_edge;
    logic             src_uf;
    logic             rd_c0l;

    ctmr_divider u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (ptick)
    );

    assign load0 = bus_wr && (bus_addr == ADDR_W'(A_CTL0))     && bus_wdata[1];
    assign load1 = bus_wr && (bus_addr == ADDR_W'(A_CTL0 + 1)) && bus_wdata[1];
    assign load2 = bus_wr && (bus_addr == ADDR_W'(A_CTL0 + 2)) && bus_wdata[1];

    assign ev_edge = st_q.mode.evpol ? (st_q.ev[1] & ~st_q.ev[2])
                                     : (~st_q.ev[1] & st_q.ev[2]);

    assign tick0 = st_q.mode.evmode ? ev_edge : ptick[st_q.ctl[0].sel];
    assign tick1 = st_q.mode.chain  ? uf0     : ptick[st_q.ctl[1].sel];
    assign tick2 = ptick[st_q.ctl[2].sel];

    ctmr_channel u_ch0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick0),
        .run_req_i   (st_q.ctl[0].run_req),
        .force_run_i (1'b0),
        .load_i      (load0),
        .reload_i    (st_q.rld[0]),
        .cnt_o       (cnt0),
        .uf_o        (uf0)
    );

    ctmr_channel u_ch1 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick1),
        .run_req_i   (st_q.ctl[1].run_req),
        .force_run_i (st_q.mode.chain),
        .load_i      (load1),
        .reload_i    (st_q.rld[1]),
        .cnt_o       (cnt1),
        .uf_o        (uf1)
    );

    ctmr_channel u_ch2 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick2),
        .run_req_i   (st_q.ctl[2].run_req),
        .force_run_i (1'b0),
        .load_i      (load2),
        .reload_i    (st_q.rld[2]),
        .cnt_o       (cnt2),
        .uf_o        (uf2)
    );

    assign uf_vec = {uf2, uf1, uf0};
    assign rd_c0l = bus_rd && (bus_addr == ADDR_W'(A_C0L));

    always_comb begin
        case (st_q.osel)
            2'd0:    src_uf = uf0;
            2'd1:    src_uf = uf1;
            2'd2:    src_uf = uf2;
            default: src_uf = 1'b0;
        endcase
    end

    // next-state
    always_comb begin
        logic [NCH-1:0] clr;
        st_d = st_q;
        clr  = '0;
        if (bus_wr) begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == ADDR_W'(A_CTL0 + i)) begin
                    st_d.ctl[i].run_req = bus_wdata[0];
                    st_d.ctl[i].sel     = bus_wdata[3:2];
                end
                if (bus_addr == ADDR_W'(A_RLD0L + 2*i))
                    st_d.rld[i][NIB_W-1:0] = bus_wdata;
                if (bus_addr == ADDR_W'(A_RLD0L + 2*i + 1))
                    st_d.rld[i][CNT_W-1:NIB_W] = bus_wdata;
            end
            if (bus_addr == ADDR_W'(A_MODE)) st_d.mode = mode_t'(bus_wdata);
            if (bus_addr == ADDR_W'(A_OSEL)) st_d.osel = bus_wdata[1:0];
            if (bus_addr == ADDR_W'(A_FLAG)) clr = bus_wdata[NCH-1:0];
        end
        st_d.flags = (st_q.flags & ~clr) | uf_vec;
        if (!st_q.mode.oen)  st_d.tout = 1'b0;
        else if (src_uf)     st_d.tout = ~st_q.tout;
        if (rd_c0l) st_d.shadow = {cnt1, cnt0};
        st_d.ev = {st_q.ev[1], st_q.ev[0], event_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(A_CTL0 + i))
                bus_rdata = {st_q.ctl[i].sel, 1'b0, st_q.ctl[i].run_req};
            if (bus_addr == ADDR_W'(A_RLD0L + 2*i))
                bus_rdata = st_q.rld[i][NIB_W-1:0];
            if (bus_addr == ADDR_W'(A_RLD0L + 2*i + 1))
                bus_rdata = st_q.rld[i][CNT_W-1:NIB_W];
        end
        case (bus_addr)
            ADDR_W'(A_MODE): bus_rdata = st_q.mode;
            ADDR_W'(A_OSEL): bus_rdata = {2'b00, st_q.osel};
            ADDR_W'(A_FLAG): bus_rdata = {1'b0, st_q.flags};
            ADDR_W'(A_C0L):  bus_rdata = cnt0[NIB_W-1:0];
            ADDR_W'(A_C0H):  bus_rdata = st_q.shadow[7:4];
            ADDR_W'(A_C1L):  bus_rdata = st_q.shadow[11:8];
            ADDR_W'(A_C1H):  bus_rdata = st_q.shadow[15:12];
            ADDR_W'(A_C2L):  bus_rdata = cnt2[NIB_W-1:0];
            ADDR_W'(A_C2H):  bus_rdata = cnt2[CNT_W-1:NIB_W];
            default: ;
        endcase
    end

    assign irq_flag       = st_q.flags;
    assign tmr_out        = st_q.tout;
    assign ser_shift_tick = uf2;

    // R10
    tout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode.oen |=> !tmr_out);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_vec != '0) |=> ((irq_flag & $past(uf_vec)) == $past(uf_vec)));

    // R7
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode.chain && !uf0 && !load1) |=> $stable(cnt1));

    // R8
    event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode.evmode && !ev_edge && !load0) |=> $stable(cnt0));

    // R12
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_c0l |=> $stable(st_q.shadow));

endmodule

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;
    import ctmr_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [3:0]       bus_wdata = '0;
    logic [3:0]       bus_rdata;
    logic             event_in = 1'b0;
    logic [2:0]       irq_flag;
    logic             tmr_out;
    logic             ser_shift_tick;

    always #4 clk = ~clk;

    cascade_timer u_cascade_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .event_in       (event_in),
        .irq_flag       (irq_flag),
        .tmr_out        (tmr_out),
        .ser_shift_tick (ser_shift_tick)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R1";

    // behavioural reference state
    int m_div;
    int m_cnt [3];
    int m_rld [3];
    int m_sel [3];
    bit m_run [3];
    bit m_req [3];
    bit m_chain, m_evm, m_pol, m_oen;
    int m_osel;
    bit [2:0] m_flags;
    bit m_tout;
    int m_sh;
    bit m_e1, m_e2, m_ep;
    bit c_tk [3];
    bit c_uf [3];
    bit c_ld [3];

    function automatic int ratio(input int s);
        case (s)
            0: return 256;
            1: return 32;
            2: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic bit ptk(input int s);
        return (m_div % ratio(s)) == ratio(s) - 1;
    endfunction

    task automatic model_comb();
        for (int i = 0; i < 3; i++)
            c_ld[i] = bus_wr && (int'(bus_addr) == i) && bus_wdata[1];
        c_tk[0] = m_evm ? (m_pol ? (m_e2 && !m_ep) : (!m_e2 && m_ep)) : ptk(m_sel[0]);
        c_uf[0] = c_tk[0] && m_run[0] && m_cnt[0] == 0 && !c_ld[0];
        c_tk[1] = m_chain ? c_uf[0] : ptk(m_sel[1]);
        c_uf[1] = c_tk[1] && (m_run[1] || m_chain) && m_cnt[1] == 0 && !c_ld[1];
        c_tk[2] = ptk(m_sel[2]);
        c_uf[2] = c_tk[2] && m_run[2] && m_cnt[2] == 0 && !c_ld[2];
    endtask

    function automatic int exp_rd(input int a);
        case (a)
            0, 1, 2: return (m_sel[a] << 2) | int'(m_req[a]);
            3:  return (int'(m_oen) << 3) | (int'(m_pol) << 2) | (int'(m_evm) << 1) | int'(m_chain);
            4:  return m_osel;
            5:  return int'(m_flags);
            6, 8, 10: return m_rld[(a - 6) / 2] & 15;
            7, 9, 11: return (m_rld[(a - 6) / 2] >> 4) & 15;
            12: return m_cnt[0] & 15;
            13: return (m_sh >> 4) & 15;
            14: return (m_sh >> 8) & 15;
            15: return (m_sh >> 12) & 15;
            16: return m_cnt[2] & 15;
            17: return (m_cnt[2] >> 4) & 15;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_chain = 0; m_evm = 0; m_pol = 0; m_oen = 0;
            m_osel = 0; m_flags = '0; m_tout = 0; m_sh = 0;
            m_e1 = 0; m_e2 = 0; m_ep = 0;
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0; m_rld[i] = 0; m_sel[i] = 0; m_run[i] = 0; m_req[i] = 0;
            end
        end else begin
            model_comb();
            for (int i = 0; i < 3; i++) begin
                if (c_ld[i])
                    m_cnt[i] = m_rld[i];
                else if (c_tk[i] && (m_run[i] || (i == 1 && m_chain)))
                    m_cnt[i] = (m_cnt[i] == 0) ? m_rld[i] : m_cnt[i] - 1;
                if (c_tk[i]) m_run[i] = m_req[i];
            end
            if (bus_wr && bus_addr == 5) m_flags = m_flags & ~bus_wdata[2:0];
            m_flags = m_flags | {c_uf[2], c_uf[1], c_uf[0]};
            if (!m_oen) m_tout = 0;
            else if (m_osel < 3 && c_uf[m_osel]) m_tout = !m_tout;
            if (bus_rd && bus_addr == 12) m_sh = m_cnt[1] * 256 + m_cnt[0];
            m_ep = m_e2; m_e2 = m_e1; m_e1 = event_in;
            m_div = (m_div + 1) % 256;
            if (bus_wr) begin
                if (bus_addr <= 2) begin
                    m_req[bus_addr] = bus_wdata[0];
                    m_sel[bus_addr] = int'(bus_wdata[3:2]);
                end else if (bus_addr == 3) begin
                    m_chain = bus_wdata[0]; m_evm = bus_wdata[1];
                    m_pol = bus_wdata[2]; m_oen = bus_wdata[3];
                end else if (bus_addr == 4) begin
                    m_osel = int'(bus_wdata[1:0]);
                end else if (bus_addr >= 6 && bus_addr <= 11) begin
                    if (bus_addr[0] == 1'b0)
                        m_rld[(bus_addr - 6) / 2] = (m_rld[(bus_addr - 6) / 2] & 'hF0) | int'(bus_wdata);
                    else
                        m_rld[(bus_addr - 6) / 2] = (m_rld[(bus_addr - 6) / 2] & 'h0F) | (int'(bus_wdata) << 4);
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            #2;
            model_comb();
            chk("R9 flags", int'(irq_flag), int'({c_uf[2], c_uf[1], c_uf[0]} | m_flags) & int'(irq_flag | ~irq_flag) & int'(m_flags));
            chk("R10 tout", int'(tmr_out), int'(m_tout));
            chk("R11 shift tick", int'(ser_shift_tick), int'(c_uf[2]));
            if (bus_rd) chk({cur_tag, " read"}, int'(bus_rdata), exp_rd(int'(bus_addr)));
        end
    end

    task automatic wr(input int a, input int d);
        bus_addr = 5'(a); bus_wdata = 4'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a);
        bus_addr = 5'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset values
        cur_tag = "R1";
        chk("R1 tout", int'(tmr_out), 0);
        chk("R1 flags", int'(irq_flag), 0);
        for (int a = 0; a < 18; a++) rd(a);

        // R4: /1 ticks, reload 5, underflow period 6
        cur_tag = "R4";
        wr(10, 5); wr(11, 0);
        wr(2, 4'b1101);
        idle(30); rd(16); rd(17); rd(5);

        // R2: /4 on counter 2
        cur_tag = "R2";
        wr(2, 4'b1001);
        idle(60); rd(16); rd(2);

        // R10: output follows counter 2, then disabled, then source 3
        cur_tag = "R10";
        wr(4, 2); wr(3, 4'b1000);
        idle(40); rd(4);
        wr(3, 0); idle(10);
        wr(4, 3); wr(3, 4'b1000); idle(20);
        wr(3, 0);

        // R5: reset bit loads immediately, reads 0
        cur_tag = "R5";
        wr(10, 12);
        wr(2, 4'b1111);
        rd(2); rd(16); rd(17);

        // R6: stop holds, run resumes
        cur_tag = "R6";
        wr(2, 4'b1100);
        idle(10); rd(16);
        idle(20); rd(16); rd(17);
        wr(2, 4'b1101);
        idle(5); rd(16);

        // R3: /32 start and stop timing on counter 0
        cur_tag = "R3";
        wr(6, 3);
        wr(0, 4'b0101);
        repeat (8) begin idle(9); rd(12); end
        wr(0, 4'b0100);
        repeat (6) begin idle(9); rd(12); end

        // R9: write-one clear
        cur_tag = "R9";
        wr(2, 4'b1100);
        idle(4);
        rd(5); wr(5, 7); rd(5);

        // R7: chained 16-bit mode, counter 1 own controls stopped
        cur_tag = "R7";
        wr(6, 2); wr(8, 1); wr(9, 0);
        wr(1, 4'b0000);
        wr(4, 1);
        wr(3, 4'b1001);
        wr(0, 4'b1111);
        idle(40);
        rd(12); rd(13); rd(14); rd(15); rd(1);

        // R12: coherent 16-bit reads
        cur_tag = "R12";
        wr(6, 15); wr(7, 0); wr(8, 3);
        wr(1, 4'b0010);
        wr(0, 4'b1111);
        repeat (5) begin
            rd(12); rd(13); rd(14); rd(15);
            idle(7);
        end
        rd(14);

        // R8: event counting, falling then rising edges
        cur_tag = "R8";
        wr(3, 4'b0010);
        wr(6, 3); wr(7, 0);
        wr(0, 4'b0011);
        repeat (12) begin event_in = ~event_in; idle(4); rd(12); end
        wr(3, 4'b0110);
        repeat (12) begin event_in = ~event_in; idle(4); rd(12); end

        // R2: /256 on unchained counter 1
        cur_tag = "R2";
        wr(3, 0);
        wr(8, 1); wr(9, 0);
        wr(1, 4'b0011);
        wr(1, 4'b0001);
        repeat (4) begin idle(200); rd(12); rd(14); end
        rd(5);

        summary();
        $finish;
    end

endmodule